// File: doc/BRIEF.md
# DDR Write-to-Read Interrupt Sequencer

This block is the command-side sequencer of a DDR SDRAM controller. It takes one host request and turns it into a WRITE burst that a READ cuts short. The READ goes to a column in the same bank. The block drives the command pins, the bank and address lines, the write strobe enable, the per-beat data mask and the column of each write beat. It delays the READ until the write-to-read turnaround has elapsed. It then captures the read data burst once the CAS latency has passed. Each clock carries two logical beats: rise first, then fall.

The host offers a request with a ready/valid handshake. A request carries the bank, the write column, the read bank, the read column and the number of data pairs to write before truncation. The configuration inputs are burst length, burst order, turnaround clocks and CAS latency. They are sampled only when a request is accepted.

The controller is built around one state machine with these states:
- `S_IDLE`: waits for a request.
- `S_WR_CMD`: drives WRITE.
- `S_WR_DATA`: drives the real data pairs.
- `S_TURN`: drives the masked pairs and counts the turnaround.
- `S_RD_CMD`: drives READ, or flags a bank mismatch.
- `S_RD_LAT`: waits for the CAS latency.
- `S_RD_DATA`: captures the read data pairs.

The transitions are:
- accept: `S_IDLE` to `S_WR_CMD`.
- issue: `S_WR_CMD` to `S_WR_DATA`.
- truncate, after the last real pair: `S_WR_DATA` to `S_TURN`.
- turnaround expired: `S_TURN` to `S_RD_CMD`.
- read issued: `S_RD_CMD` to `S_RD_LAT`.
- bank mismatch: `S_RD_CMD` to `S_IDLE`.
- latency expired: `S_RD_LAT` to `S_RD_DATA`.
- burst complete: `S_RD_DATA` to `S_IDLE`.

Top module: `ddr_wr_rd_interrupt_seq`

## Requirements
- R1: After reset the block shows the following at its ports:
  - `req_ready` is 1.
  - `cmd_n` is NOP. `cmd_n` is {cs_n, ras_n, cas_n, we_n}: NOP = 0111, WRITE = 0100, READ = 0101.
  - `wr_strobe_en` is 0 and `wr_dm` is 00.
  - `rd_valid` is 0 and `err_bank` is 0.
- R2: A request is accepted at a clock edge where `req_valid` and `req_ready` are both high. In the next cycle (cycle 1) the block drives:
  - WRITE on `cmd_n`;
  - `cmd_bank` = the request bank;
  - `cmd_addr` = the write column, zero-extended, with bit 10 (the auto-precharge bit) low.
- R3: Let P be the programmed pairs: `req_pairs` clamped to the range 1 to BL/2, with 0 treated as 1. For the P cycles after WRITE (cycles 2 to L, where L = P+1), `wr_strobe_en` is 1 and `wr_dm` is 00. `wr_dm` bit 0 masks the rise beat and bit 1 masks the fall beat.
- R4: The beat columns follow the configured burst order. The burst length is set by `cfg_bl`: 3 gives BL 8, 2 gives BL 4, and any other value gives BL 2. Element i of the burst lies in the aligned block of BL columns that holds the start column. Within that block its low bits are:
  - sequential order (`cfg_interleave` = 0): (start + i) mod BL;
  - interleaved order (`cfg_interleave` = 1): start XOR i.

  In the k-th strobed pair, `wr_col_rise` is element 2k and `wr_col_fall` is element 2k+1.
- R5: After cycle L the block drives M = BL/2 - P more cycles with `wr_strobe_en` 1 and `wr_dm` 11, and the columns keep advancing. After those cycles `wr_strobe_en` stays 0 until the next request.
- R6: READ is driven with `cmd_addr` = the read column in cycle L + 1 + max(T + 1, M). T is `cfg_twtr`, with 0 treated as 1. The extra clock covers the latest strobe skew. NOP is driven in every cycle that has no WRITE or READ.
- R7: If the read bank differs from the write bank, the READ cycle instead drives NOP and raises `err_bank` for that one cycle. No read data is captured, and `req_ready` returns in the next cycle.
- R8: Let the READ be in cycle R and let C be the CAS latency: `cfg_cl`, with values below 2 treated as 2. The block samples `rd_dq_rise`/`rd_dq_fall` in cycles R+C to R+C+BL/2-1. It presents each sample on `rd_data_rise`/`rd_data_fall` with `rd_valid` high in the following cycle.
- R9: `req_ready` is high only while idle. It stays low from cycle 1 until cycle R+C+BL/2, when it returns high.
- R10: Changes on the `cfg_*` and `req_*` inputs while a request is in progress have no effect on that request's sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_bank | input | BANK_W | Bank of the WRITE |
| req_wr_col | input | COL_W | Start column of the WRITE |
| req_rd_bank | input | BANK_W | Bank of the interrupting READ |
| req_rd_col | input | COL_W | Column of the READ |
| req_pairs | input | 3 | Data pairs written before truncation |
| cfg_bl | input | 2 | Burst length code (3 = 8, 2 = 4, other = 2) |
| cfg_interleave | input | 1 | Burst order: 0 sequential, 1 interleaved |
| cfg_twtr | input | TWTR_W | Write-to-read turnaround in clocks |
| cfg_cl | input | 2 | CAS latency in clocks |
| cmd_n | output | 4 | {cs_n, ras_n, cas_n, we_n} |
| cmd_bank | output | BANK_W | Bank lines |
| cmd_addr | output | ADDR_W | Address lines |
| wr_strobe_en | output | 1 | Write strobe toggles on both beats of this clock |
| wr_dm | output | 2 | Data mask {fall, rise} |
| wr_col_rise | output | COL_W | Column of the rise write beat |
| wr_col_fall | output | COL_W | Column of the fall write beat |
| rd_dq_rise | input | DW | Read data on the rising beat |
| rd_dq_fall | input | DW | Read data on the falling beat |
| rd_valid | output | 1 | Captured read pair valid |
| rd_data_rise | output | DW | Captured rise beat |
| rd_data_fall | output | DW | Captured fall beat |
| err_bank | output | 1 | READ bank differs from WRITE bank |

## Verification
Every wrong internal state in this block shows up at the ports within one request, and in a fixed cycle counted from acceptance.
- A pair counter that is off by one moves the last unmasked cycle. This is seen in cycle L. It also shifts the position of READ.
- A wrong mask count changes how long the strobe stays on after cycle L.
- A wrong turnaround or latency load moves the READ cycle, the `rd_valid` window or the return of `req_ready` by a whole clock.

The bench records every port in every cycle of a request and compares the whole timeline, so any of these errors is found in the request where it happens.

// File: rtl/wri_pkg.sv
package wri_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_WR_CMD,
        S_WR_DATA,
        S_TURN,
        S_RD_CMD,
        S_RD_LAT,
        S_RD_DATA
    } seq_state_t;

    // {cs_n, ras_n, cas_n, we_n}
    localparam logic [3:0] CMD_NOP   = 4'b0111;
    localparam logic [3:0] CMD_WRITE = 4'b0100;
    localparam logic [3:0] CMD_READ  = 4'b0101;

    // Data pairs in one burst for a burst-length code
    function automatic logic [2:0] pairs_of_bl(input logic [1:0] code);
        unique case (code)
            2'd3:    return 3'd4;
            2'd2:    return 3'd2;
            default: return 3'd1;
        endcase
    endfunction

endpackage

// File: rtl/wri_burst_col.sv
module wri_burst_col #(
    parameter int COL_W = 10
) (
    input  logic [COL_W-1:0] base_col,
    input  logic [2:0]       burst_pairs,
    input  logic             interleave,
    input  logic [2:0]       elem_idx,
    output logic [COL_W-1:0] elem_col
);
    logic [2:0] span_mask;
    logic [2:0] low_bits;

    always_comb begin
        unique case (burst_pairs)
            3'd4:    span_mask = 3'b111;
            3'd2:    span_mask = 3'b011;
            default: span_mask = 3'b001;
        endcase
        low_bits = interleave ? (base_col[2:0] ^ elem_idx)
                              : (base_col[2:0] + elem_idx);
        elem_col      = base_col;
        elem_col[2:0] = (base_col[2:0] & ~span_mask) | (low_bits & span_mask);
    end

endmodule

// File: rtl/wri_down_cnt.sv
module wri_down_cnt #(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             at_one
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign at_one = (cnt_q == CNT_W'(1));

endmodule

// File: rtl/ddr_wr_rd_interrupt_seq.sv
module ddr_wr_rd_interrupt_seq
    import wri_pkg::*;
#(
    parameter int COL_W  = 10,
    parameter int ADDR_W = 13,
    parameter int AP_BIT = 10,
    parameter int BANK_W = 2,
    parameter int DW     = 16,
    parameter int TWTR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [BANK_W-1:0] req_bank,
    input  logic [COL_W-1:0]  req_wr_col,
    input  logic [BANK_W-1:0] req_rd_bank,
    input  logic [COL_W-1:0]  req_rd_col,
    input  logic [2:0]        req_pairs,
    input  logic [1:0]        cfg_bl,
    input  logic              cfg_interleave,
    input  logic [TWTR_W-1:0] cfg_twtr,
    input  logic [1:0]        cfg_cl,
    output logic [3:0]        cmd_n,
    output logic [BANK_W-1:0] cmd_bank,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              wr_strobe_en,
    output logic [1:0]        wr_dm,
    output logic [COL_W-1:0]  wr_col_rise,
    output logic [COL_W-1:0]  wr_col_fall,
    input  logic [DW-1:0]     rd_dq_rise,
    input  logic [DW-1:0]     rd_dq_fall,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data_rise,
    output logic [DW-1:0]     rd_data_fall,
    output logic              err_bank
);
    localparam int CNT_W = TWTR_W + 1;
    localparam int PAD_W = ADDR_W - COL_W;

    seq_state_t state_q, state_d;

    logic [BANK_W-1:0] bank_q, rd_bank_q;
    logic [COL_W-1:0]  wcol_q, rcol_q;
    logic [2:0]        npairs_q, bpairs_q, pidx_q, mask_q;
    logic              il_q;
    logic [TWTR_W-1:0] twtr_q;
    logic [1:0]        cl_q;
    logic              rd_valid_q;
    logic [DW-1:0]     rd_rise_q, rd_fall_q;

    logic              cnt_load, cnt_one;
    logic [CNT_W-1:0]  cnt_val;
    logic              accept, last_pair, bank_ok;
    logic [2:0]        acc_bp, acc_np;
    logic [CNT_W-1:0]  turn_wait, mask_left;

    assign accept    = (state_q == S_IDLE) && req_valid;
    assign last_pair = (state_q == S_WR_DATA) && (pidx_q == npairs_q - 3'd1);
    assign bank_ok   = (rd_bank_q == bank_q);
    assign acc_bp    = pairs_of_bl(cfg_bl);
    assign acc_np    = (req_pairs == 3'd0) ? 3'd1 :
                       (req_pairs > acc_bp) ? acc_bp : req_pairs;

    // Turnaround: T + 1 for latest strobe skew, but never less than the masked pairs
    assign mask_left = CNT_W'(bpairs_q - npairs_q);
    assign turn_wait = (CNT_W'(twtr_q) + CNT_W'(1) > mask_left)
                     ? CNT_W'(twtr_q) + CNT_W'(1) : mask_left;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= S_IDLE;
        else
            state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (req_valid) state_d = S_WR_CMD;
            S_WR_CMD:  state_d = S_WR_DATA;
            S_WR_DATA: if (last_pair) state_d = S_TURN;
            S_TURN:    if (cnt_one) state_d = S_RD_CMD;
            S_RD_CMD:  state_d = bank_ok ? S_RD_LAT : S_IDLE;
            S_RD_LAT:  if (cnt_one) state_d = S_RD_DATA;
            S_RD_DATA: if (cnt_one) state_d = S_IDLE;
            default:   state_d = S_IDLE;
        endcase
    end

    // Request and configuration capture, beat bookkeeping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bank_q   <= '0;
            rd_bank_q <= '0;
            wcol_q   <= '0;
            rcol_q   <= '0;
            npairs_q <= 3'd1;
            bpairs_q <= 3'd1;
            il_q     <= 1'b0;
            twtr_q   <= TWTR_W'(1);
            cl_q     <= 2'd2;
            pidx_q   <= '0;
            mask_q   <= '0;
        end else begin
            if (accept) begin
                bank_q    <= req_bank;
                rd_bank_q <= req_rd_bank;
                wcol_q    <= req_wr_col;
                rcol_q    <= req_rd_col;
                npairs_q  <= acc_np;
                bpairs_q  <= acc_bp;
                il_q      <= cfg_interleave;
                twtr_q    <= (cfg_twtr == '0) ? TWTR_W'(1) : cfg_twtr;
                cl_q      <= (cfg_cl < 2'd2) ? 2'd2 : cfg_cl;
            end
            if (state_q == S_WR_CMD)
                pidx_q <= '0;
            else if (state_q == S_WR_DATA)
                pidx_q <= pidx_q + 3'd1;
            else if (state_q == S_TURN && mask_q != '0)
                pidx_q <= pidx_q + 3'd1;
            if (last_pair)
                mask_q <= bpairs_q - npairs_q;
            else if (state_q == S_TURN && mask_q != '0)
                mask_q <= mask_q - 3'd1;
        end
    end

    // Counter control: turnaround, then CAS latency, then read burst length
    always_comb begin
        cnt_load = 1'b0;
        cnt_val  = '0;
        if (last_pair) begin
            cnt_load = 1'b1;
            cnt_val  = turn_wait;
        end else if (state_q == S_RD_CMD) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(cl_q) - CNT_W'(1);
        end else if (state_q == S_RD_LAT && cnt_one) begin
            cnt_load = 1'b1;
            cnt_val  = CNT_W'(bpairs_q);
        end
    end

    wri_down_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .at_one   (cnt_one)
    );

    wri_burst_col #(.COL_W(COL_W)) u_col_rise (
        .base_col    (wcol_q),
        .burst_pairs (bpairs_q),
        .interleave  (il_q),
        .elem_idx    ({pidx_q[1:0], 1'b0}),
        .elem_col    (wr_col_rise)
    );

    wri_burst_col #(.COL_W(COL_W)) u_col_fall (
        .base_col    (wcol_q),
        .burst_pairs (bpairs_q),
        .interleave  (il_q),
        .elem_idx    ({pidx_q[1:0], 1'b1}),
        .elem_col    (wr_col_fall)
    );

    // Outputs
    always_comb begin
        req_ready    = (state_q == S_IDLE);
        cmd_n        = CMD_NOP;
        cmd_bank     = bank_q;
        cmd_addr     = '0;
        wr_strobe_en = 1'b0;
        wr_dm        = 2'b00;
        err_bank     = 1'b0;
        unique case (state_q)
            S_WR_CMD: begin
                cmd_n    = CMD_WRITE;
                cmd_addr = {{PAD_W{1'b0}}, wcol_q};
            end
            S_WR_DATA: wr_strobe_en = 1'b1;
            S_TURN: begin
                wr_strobe_en = (mask_q != '0);
                wr_dm        = (mask_q != '0) ? 2'b11 : 2'b00;
            end
            S_RD_CMD: begin
                if (bank_ok) begin
                    cmd_n    = CMD_READ;
                    cmd_addr = {{PAD_W{1'b0}}, rcol_q};
                end else begin
                    err_bank = 1'b1;
                end
            end
            default: ;
        endcase
    end

    // Read capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_rise_q  <= '0;
            rd_fall_q  <= '0;
        end else begin
            rd_valid_q <= (state_q == S_RD_DATA);
            if (state_q == S_RD_DATA) begin
                rd_rise_q <= rd_dq_rise;
                rd_fall_q <= rd_dq_fall;
            end
        end
    end

    assign rd_valid     = rd_valid_q;
    assign rd_data_rise = rd_rise_q;
    assign rd_data_fall = rd_fall_q;

    // Clocks since the last unmasked write pair (checking only)
    logic [5:0] gap_q;
    always_ff @(posedge clk) begin
        if (!rst_n)
            gap_q <= 6'h3f;
        else if (wr_strobe_en && wr_dm == 2'b00)
            gap_q <= '0;
        else if (gap_q != 6'h3f)
            gap_q <= gap_q + 6'd1;
    end

    initial begin
        assert (AP_BIT >= COL_W && AP_BIT < ADDR_W) else $error("column overlaps auto-precharge bit");
    end

    p_write_after_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (cmd_n == CMD_WRITE && !cmd_addr[AP_BIT]));

    p_mask_with_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_dm != 2'b00) |-> wr_strobe_en);

    p_twtr_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == CMD_READ) |-> (gap_q >= 6'(twtr_q) + 6'd1 && !wr_strobe_en));

    p_read_same_bank_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_n == CMD_READ) |-> (rd_bank_q == cmd_bank && !err_bank));

    p_ready_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (cmd_n == CMD_NOP && !wr_strobe_en));

    p_capture_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> (!wr_strobe_en && cmd_n == CMD_NOP));

endmodule

// File: tb/ddr_wr_rd_interrupt_seq_tb.sv
`timescale 1ns/1ps
module ddr_wr_rd_interrupt_seq_tb;
    localparam int COL_W = 10, ADDR_W = 13, BANK_W = 2, DW = 16, TWTR_W = 4;
    localparam int TMAX = 30;
    localparam logic [3:0] NOP = 4'b0111, WR = 4'b0100, RD = 4'b0101;

    logic clk = 1'b0, rst_n = 1'b0;
    logic req_valid = 1'b0, req_ready;
    logic [BANK_W-1:0] req_bank = '0, req_rd_bank = '0;
    logic [COL_W-1:0]  req_wr_col = '0, req_rd_col = '0;
    logic [2:0]        req_pairs = 3'd1;
    logic [1:0]        cfg_bl = 2'd2, cfg_cl = 2'd2;
    logic              cfg_interleave = 1'b0;
    logic [TWTR_W-1:0] cfg_twtr = 4'd1;
    logic [3:0]        cmd_n;
    logic [BANK_W-1:0] cmd_bank;
    logic [ADDR_W-1:0] cmd_addr;
    logic              wr_strobe_en, rd_valid, err_bank;
    logic [1:0]        wr_dm;
    logic [COL_W-1:0]  wr_col_rise, wr_col_fall;
    logic [DW-1:0]     rd_dq_rise = '0, rd_dq_fall = '0, rd_data_rise, rd_data_fall;

    int n_total = 0, n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ddr_wr_rd_interrupt_seq u_dut (.*);

    logic [3:0]        s_cmd  [0:TMAX];
    logic [ADDR_W-1:0] s_addr [0:TMAX];
    logic [BANK_W-1:0] s_bank [0:TMAX];
    logic              s_stb  [0:TMAX];
    logic [1:0]        s_dm   [0:TMAX];
    logic [COL_W-1:0]  s_cr   [0:TMAX];
    logic [COL_W-1:0]  s_cf   [0:TMAX];
    logic              s_rdy  [0:TMAX];
    logic              s_rv   [0:TMAX];
    logic [DW-1:0]     s_rr   [0:TMAX];
    logic [DW-1:0]     s_rf   [0:TMAX];
    logic              s_err  [0:TMAX];

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_total++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    function automatic int exp_col(input int base, input int bp, input bit il, input int i);
        int span = 2 * bp;
        int low  = base % span;
        int off  = il ? (low ^ i) : ((low + i) % span);
        return base - low + off;
    endfunction

    task automatic test_reset();
        @(negedge clk);
        check(req_ready == 1'b1, "R1", "ready", int'(req_ready), 1);
        check(cmd_n == NOP, "R1", "cmd", int'(cmd_n), int'(NOP));
        check(wr_strobe_en == 1'b0 && wr_dm == 2'b00, "R1", "strobe/dm",
              int'({wr_strobe_en, wr_dm}), 0);
        check(rd_valid == 1'b0 && err_bank == 1'b0, "R1", "rd_valid/err",
              int'({rd_valid, err_bank}), 0);
    endtask

    // One request; scramble changes every request/config input while busy (R10)
    task automatic run_case(input string name, input int blc, input bit il, input int pairs_in,
                            input int twtr_in, input int cl_in, input int bank, input int rbank,
                            input int wcol, input int rcol, input bit scramble);
        int bp, np, tw, cl, m, l, w, r, t_idle, bad_t, a, e;
        bit match, ok;
        bp = (blc == 3) ? 4 : (blc == 2) ? 2 : 1;
        np = (pairs_in == 0) ? 1 : (pairs_in > bp) ? bp : pairs_in;
        tw = (twtr_in == 0) ? 1 : twtr_in;
        cl = (cl_in < 2) ? 2 : cl_in;
        m  = bp - np;
        l  = np + 1;
        w  = (tw + 1 > m) ? tw + 1 : m;
        r  = l + 1 + w;
        match  = (bank == rbank);
        t_idle = match ? r + cl + bp : r + 1;

        @(negedge clk);
        check(req_ready == 1'b1, "R9", {name, " ready before accept"}, int'(req_ready), 1);
        req_valid      = 1'b1;
        req_bank       = BANK_W'(bank);
        req_rd_bank    = BANK_W'(rbank);
        req_wr_col     = COL_W'(wcol);
        req_rd_col     = COL_W'(rcol);
        req_pairs      = 3'(pairs_in);
        cfg_bl         = 2'(blc);
        cfg_interleave = il;
        cfg_twtr       = TWTR_W'(twtr_in);
        cfg_cl         = 2'(cl_in);
        for (int t = 1; t <= TMAX; t++) begin
            @(negedge clk);
            s_cmd[t] = cmd_n;   s_addr[t] = cmd_addr; s_bank[t] = cmd_bank;
            s_stb[t] = wr_strobe_en; s_dm[t] = wr_dm;
            s_cr[t]  = wr_col_rise;  s_cf[t] = wr_col_fall;
            s_rdy[t] = req_ready;    s_rv[t] = rd_valid;
            s_rr[t]  = rd_data_rise; s_rf[t] = rd_data_fall; s_err[t] = err_bank;
            req_valid  = 1'b0;
            rd_dq_rise = DW'(16'h1000 + t);
            rd_dq_fall = DW'(16'h2000 + t);
            if (scramble && t == 2) begin
                req_bank = ~req_bank; req_rd_bank = ~req_rd_bank;
                req_wr_col = ~req_wr_col; req_rd_col = ~req_rd_col; req_pairs = 3'd0;
                cfg_bl = 2'd1; cfg_interleave = ~cfg_interleave;
                cfg_twtr = 4'd9; cfg_cl = 2'd3;
            end
        end

        // R2: WRITE in cycle 1
        check(s_cmd[1] == WR && s_addr[1] == ADDR_W'(wcol) && s_bank[1] == BANK_W'(bank),
              "R2", {name, " WRITE cmd/addr"}, int'({s_cmd[1], s_addr[1]}), int'({WR, ADDR_W'(wcol)}));

        // R3: unmasked pairs
        ok = 1'b1; bad_t = 0;
        for (int t = 2; t <= l; t++)
            if (ok && !(s_stb[t] == 1'b1 && s_dm[t] == 2'b00)) begin ok = 1'b0; bad_t = t; end
        check(ok, "R3", {name, " data pairs"}, ok ? 0 : int'({s_stb[bad_t], s_dm[bad_t]}), 4);

        // R4: beat columns
        ok = 1'b1; a = 0; e = 0;
        for (int t = 2; t <= l + m; t++) begin
            int k = t - 2;
            if (ok && (int'(s_cr[t]) != exp_col(wcol, bp, il, 2*k) ||
                       int'(s_cf[t]) != exp_col(wcol, bp, il, 2*k+1))) begin
                ok = 1'b0; a = int'({s_cr[t], s_cf[t]});
                e = (exp_col(wcol, bp, il, 2*k) << COL_W) | exp_col(wcol, bp, il, 2*k+1);
            end
        end
        check(ok, "R4", {name, " beat columns"}, a, e);

        // R5: masked pairs then strobe off
        ok = 1'b1; a = 0; e = 0;
        for (int t = l + 1; t <= TMAX; t++) begin
            bit es = (t <= l + m);
            if (ok && (s_stb[t] != es || s_dm[t] != (es ? 2'b11 : 2'b00))) begin
                ok = 1'b0; a = int'({s_stb[t], s_dm[t]}); e = es ? 7 : 0;
            end
        end
        check(ok, "R5", {name, " mask tail"}, a, e);

        // R6 / R7: command timeline after the WRITE
        ok = 1'b1; a = 0; e = 0;
        for (int t = 2; t <= TMAX; t++) begin
            logic [3:0] ec = (match && t == r) ? RD : NOP;
            if (ok && (s_cmd[t] != ec || (ec == RD && s_addr[t] != ADDR_W'(rcol)))) begin
                ok = 1'b0; a = (t << 8) | int'(s_cmd[t]); e = (t << 8) | int'(ec);
            end
        end
        check(ok, match ? "R6" : "R7", {name, " command timeline"}, a, e);
        ok = 1'b1; a = 0; e = 0;
        for (int t = 1; t <= TMAX; t++) begin
            bit ee = (!match && t == r);
            if (ok && s_err[t] != ee) begin ok = 1'b0; a = (t << 4) | int'(s_err[t]); e = (t << 4) | int'(ee); end
        end
        check(ok, "R7", {name, " err_bank"}, a, e);

        // R8: captured read data
        ok = 1'b1; a = 0; e = 0;
        for (int t = 1; t <= TMAX; t++) begin
            bit ev = match && (t >= r + cl + 1) && (t <= r + cl + bp);
            if (ok && s_rv[t] != ev) begin ok = 1'b0; a = (t << 4) | int'(s_rv[t]); e = (t << 4) | int'(ev); end
            if (ok && ev && (int'(s_rr[t]) != 16'h1000 + t - 1 || int'(s_rf[t]) != 16'h2000 + t - 1)) begin
                ok = 1'b0; a = int'({s_rr[t], s_rf[t]});
                e = ((16'h1000 + t - 1) << 16) | (16'h2000 + t - 1);
            end
        end
        check(ok, "R8", {name, " read capture"}, a, e);

        // R9: ready timeline
        ok = 1'b1; a = 0; e = 0;
        for (int t = 1; t <= TMAX; t++) begin
            bit er = (t >= t_idle);
            if (ok && s_rdy[t] != er) begin ok = 1'b0; a = (t << 4) | int'(s_rdy[t]); e = (t << 4) | int'(er); end
        end
        check(ok, "R9", {name, " ready timeline"}, a, e);

        if (scramble)
            check(s_cmd[r] == RD && s_bank[r] == BANK_W'(bank) && s_addr[r] == ADDR_W'(rcol),
                  "R10", {name, " inputs changed while busy"}, int'(s_cmd[r]), int'(RD));
    endtask

    task automatic test_bl4_seq();     run_case("bl4_seq",    2, 1'b0, 1, 1, 2, 1, 1, 10'h005, 10'h120, 1'b0); endtask
    task automatic test_bl8_il();      run_case("bl8_il",     3, 1'b1, 1, 1, 3, 2, 2, 10'h00B, 10'h033, 1'b0); endtask
    task automatic test_bl8_seq_long();run_case("bl8_seq",    3, 1'b0, 2, 4, 2, 3, 3, 10'h1FE, 10'h044, 1'b0); endtask
    task automatic test_bl2();         run_case("bl2",        1, 1'b0, 1, 2, 2, 0, 0, 10'h0A3, 10'h0A4, 1'b0); endtask
    task automatic test_clamp_lo();    run_case("pairs0",     2, 1'b1, 0, 0, 0, 1, 1, 10'h002, 10'h002, 1'b0); endtask
    task automatic test_clamp_hi();    run_case("pairs7",     2, 1'b0, 7, 3, 3, 2, 2, 10'h00F, 10'h3FF, 1'b0); endtask
    task automatic test_bank_err();    run_case("bank_err",   3, 1'b0, 3, 2, 2, 1, 2, 10'h010, 10'h020, 1'b0); endtask
    task automatic test_busy_change(); run_case("busy_chg",   3, 1'b0, 1, 2, 2, 2, 2, 10'h006, 10'h055, 1'b1); endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        test_reset();
        test_bl4_seq();
        test_bl8_il();
        test_bl8_seq_long();
        test_bl2();
        test_clamp_lo();
        test_clamp_hi();
        test_bank_err();
        test_busy_change();
        test_bl4_seq();
        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_total++;
            n_bad++;
            $display("FAIL watchdog: actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", n_total, n_bad);
            $finish;
        end
    end

endmodule